// File: doc/BRIEF.md
# Sampling Performance Event Counter

This block counts hardware events and raises a sampling interrupt at a programmed point. It has two sampling modes. In event mode, each event pulse that qualifies adds one to the count. The interrupt fires when the count reaches a programmed limit. In time mode, every enabled clock cycle adds one to the count, and the same limit then acts as a period. The counter clears to zero when the interrupt fires and keeps counting. The interrupt line stays high until software clears it.

Two filters decide whether an event qualifies:
- **Privilege filter:** the event counts only if the current privilege level is one that software has allowed.
- **Latency filter:** when turned on, only events whose reported latency is at or above a programmed minimum count. This lets the counter follow, for example, only slow memory misses.

All state can be read and written through a small register port. Software can therefore save the count and the configuration and restore them later.

Top module: `perf_sample_counter`

## Requirements
- R1: After a synchronous reset, `count_o` is 0, `irq_o` is low, and every configuration field is 0, so the counter is disabled.
- R2: In event mode (control bit 1 = 0) with the counter enabled (control bit 0 = 1), each cycle with a qualifying `ev_pulse_i` raises `count_o` by one at the next clock edge.
- R3: When an increment would make the count equal to the active limit, the same edge sets `irq_o` and loads `count_o` with 0. Counting then continues from 0.
- R4: Control bit 2 allows user level (`priv_i` = 0) and control bit 3 allows kernel level (`priv_i` = 1). In event mode, a pulse seen at a level that is not allowed leaves `count_o` unchanged.
- R5: When control bit 4 is set, a pulse counts only if `ev_lat_i` is greater than or equal to the latency minimum register. Shorter pulses leave `count_o` unchanged.
- R6: `irq_o` stays high until a write to the control register with bit 8 set. That write clears the flag while its bits 4:0 still load the configuration. If a new firing happens in the same cycle as the clear, the firing wins.
- R7: A limit written while the counter is enabled takes effect only after the next firing. A limit written while the counter is disabled takes effect at once. A limit of 0 never fires.
- R8: With control bit 0 clear, `count_o` holds its value.
- R9: In time mode (control bit 1 = 1), `count_o` rises by one on every enabled cycle, whatever the event, latency and privilege inputs are, and fires against the limit as in R3.
- R10: The register port uses these addresses: 0 = control, 1 = limit, 2 = latency minimum, 3 = count. A read of the control register returns the configuration in bits 4:0 and the interrupt flag in bit 8. `cfg_rdata_o` follows `cfg_addr_i` combinationally. A write to the count loads the written value and cancels any increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address for read and write |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for `cfg_addr_i` |
| ev_pulse_i | input | 1 | One event per cycle while high |
| ev_lat_i | input | LAT_W (12) | Latency reported with the event |
| priv_i | input | 1 | Current privilege level: 0 user, 1 kernel |
| count_o | output | 32 | Live count value |
| irq_o | output | 1 | Sticky sampling interrupt |

## Verification
The hardest case to reach from the ports is a limit rewritten while the counter is enabled, where the count already sits between the new limit and the old one. The stimulus first counts up to 3 with an active limit of 5. It then writes a limit of 3 and sends two more pulses, so the firing must happen at 5 and not at 3. After that, three further pulses must fire at the new limit. The latency and privilege filters are each tested with pulses just below, at and above the cut-off, and at allowed and refused levels, in the same run.

// File: rtl/perf_sample_pkg.sv
package perf_sample_pkg;

    localparam int ADDR_W   = 3;
    localparam int CLR_BIT  = 8;
    localparam int CTRL_W   = 5;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_LIMIT  = 3'd1,
        REG_LATMIN = 3'd2,
        REG_COUNT  = 3'd3
    } reg_sel_e;

    typedef enum logic {
        SAMPLE_EVENT = 1'b0,
        SAMPLE_TIME  = 1'b1
    } sample_mode_e;

    typedef enum logic {
        PRIV_USER   = 1'b0,
        PRIV_KERNEL = 1'b1
    } priv_e;

    // packed: enable is bit 0, lat_filt is bit 4
    typedef struct packed {
        logic         lat_filt;
        logic         allow_kernel;
        logic         allow_user;
        sample_mode_e mode;
        logic         enable;
    } ctrl_t;

    function automatic logic level_allowed(ctrl_t c, priv_e p);
        return (p == PRIV_KERNEL) ? c.allow_kernel : c.allow_user;
    endfunction

endpackage

// File: rtl/perf_cfg_regs.sv
module perf_cfg_regs
    import perf_sample_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LAT_W  = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [DATA_W-1:0]               count,
    input  logic                            irq,
    output ctrl_t                           ctrl,
    output logic [DATA_W-1:0]               limit_shadow,
    output logic [LAT_W-1:0]                lat_min,
    output logic                            count_wr,
    output logic                            irq_clr,
    output logic [DATA_W-1:0]               rdata
);

    logic hit_ctrl, hit_limit, hit_lat;

    always_comb begin
        hit_ctrl  = we && (addr == REG_CTRL);
        hit_limit = we && (addr == REG_LIMIT);
        hit_lat   = we && (addr == REG_LATMIN);
        count_wr  = we && (addr == REG_COUNT);
        irq_clr   = hit_ctrl && wdata[CLR_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl         <= '0;
            limit_shadow <= '0;
            lat_min      <= '0;
        end else begin
            if (hit_ctrl)  ctrl         <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (hit_limit) limit_shadow <= wdata;
            if (hit_lat)   lat_min      <= wdata[LAT_W-1:0];
        end
    end

    always_comb begin
        case (reg_sel_e'(addr))
            REG_CTRL:   rdata = DATA_W'({irq, 3'b000, ctrl});
            REG_LIMIT:  rdata = limit_shadow;
            REG_LATMIN: rdata = DATA_W'(lat_min);
            REG_COUNT:  rdata = count;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/perf_event_qual.sv
module perf_event_qual
    import perf_sample_pkg::*;
#(
    parameter int LAT_W = 12
) (
    input  ctrl_t             ctrl,
    input  logic              ev_pulse,
    input  logic [LAT_W-1:0]  ev_lat,
    input  logic [LAT_W-1:0]  lat_min,
    input  logic              priv,
    output logic              qual,
    output logic              tick
);

    logic lat_ok;

    always_comb begin
        lat_ok = !ctrl.lat_filt || (ev_lat >= lat_min);
        qual   = ev_pulse && lat_ok && level_allowed(ctrl, priv_e'(priv));
        tick   = ctrl.enable && ((ctrl.mode == SAMPLE_TIME) || qual);
    end

endmodule

// File: rtl/perf_sample_core.sv
module perf_sample_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              tick,
    input  logic [DATA_W-1:0] limit_shadow,
    input  logic              count_wr,
    input  logic [DATA_W-1:0] count_wdata,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] count,
    output logic              irq,
    output logic              fire
);

    logic [DATA_W-1:0] active_limit;
    logic [DATA_W-1:0] count_next;

    always_comb begin
        count_next = count + 1'b1;
        fire = tick && !count_wr && (active_limit != '0) && (count_next == active_limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count        <= '0;
            irq          <= 1'b0;
            active_limit <= '0;
        end else begin
            if (!enable || fire) active_limit <= limit_shadow;

            if (count_wr)  count <= count_wdata;
            else if (fire) count <= '0;
            else if (tick) count <= count_next;

            if (fire)         irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end

endmodule

// File: rtl/perf_sample_counter.sv
module perf_sample_counter
    import perf_sample_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LAT_W  = 12
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               cfg_we_i,
    input  logic [2:0]         cfg_addr_i,
    input  logic [DATA_W-1:0]  cfg_wdata_i,
    output logic [DATA_W-1:0]  cfg_rdata_o,
    input  logic               ev_pulse_i,
    input  logic [LAT_W-1:0]   ev_lat_i,
    input  logic               priv_i,
    output logic [DATA_W-1:0]  count_o,
    output logic               irq_o
);

    ctrl_t              ctrl_q;
    logic [DATA_W-1:0]  limit_shadow;
    logic [LAT_W-1:0]   lat_min;
    logic               count_wr, irq_clr;
    logic               qual, tick, fire;

    perf_cfg_regs #(.DATA_W(DATA_W), .LAT_W(LAT_W)) u_regs (
        .clk          (clk_i),
        .rst          (rst_i),
        .we           (cfg_we_i),
        .addr         (cfg_addr_i),
        .wdata        (cfg_wdata_i),
        .count        (count_o),
        .irq          (irq_o),
        .ctrl         (ctrl_q),
        .limit_shadow (limit_shadow),
        .lat_min      (lat_min),
        .count_wr     (count_wr),
        .irq_clr      (irq_clr),
        .rdata        (cfg_rdata_o)
    );

    perf_event_qual #(.LAT_W(LAT_W)) u_qual (
        .ctrl     (ctrl_q),
        .ev_pulse (ev_pulse_i),
        .ev_lat   (ev_lat_i),
        .lat_min  (lat_min),
        .priv     (priv_i),
        .qual     (qual),
        .tick     (tick)
    );

    perf_sample_core #(.DATA_W(DATA_W)) u_core (
        .clk          (clk_i),
        .rst          (rst_i),
        .enable       (ctrl_q.enable),
        .tick         (tick),
        .limit_shadow (limit_shadow),
        .count_wr     (count_wr),
        .count_wdata  (cfg_wdata_i),
        .irq_clr      (irq_clr),
        .count        (count_o),
        .irq          (irq_o),
        .fire         (fire)
    );

endmodule

// File: rtl/perf_sample_checker.sv
module perf_sample_checker
    import perf_sample_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LAT_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input ctrl_t             ctrl,
    input logic [LAT_W-1:0]  lat_min,
    input logic              ev_pulse,
    input logic [LAT_W-1:0]  ev_lat,
    input logic              priv,
    input logic              count_wr,
    input logic              irq_clr,
    input logic [DATA_W-1:0] count,
    input logic              irq
);

    a_r6_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    a_r8_disabled_holds: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.enable && !count_wr) |=> $stable(count));

    a_r4_priv_block: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && ctrl.mode == SAMPLE_EVENT && !count_wr &&
         ((priv && !ctrl.allow_kernel) || (!priv && !ctrl.allow_user)))
        |=> $stable(count));

    a_r5_latency_block: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && ctrl.mode == SAMPLE_EVENT && ctrl.lat_filt &&
         !count_wr && ev_pulse && (ev_lat < lat_min))
        |=> $stable(count));

    a_r3_fire_clears: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (count == '0));

    a_r9_time_step: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && ctrl.mode == SAMPLE_TIME && !count_wr)
        |=> ((count == DATA_W'($past(count) + 1'b1)) || (count == '0)));

endmodule

bind perf_sample_counter perf_sample_checker #(.DATA_W(DATA_W), .LAT_W(LAT_W)) u_chk (
    .clk      (clk_i),
    .rst      (rst_i),
    .ctrl     (ctrl_q),
    .lat_min  (lat_min),
    .ev_pulse (ev_pulse_i),
    .ev_lat   (ev_lat_i),
    .priv     (priv_i),
    .count_wr (count_wr),
    .irq_clr  (irq_clr),
    .count    (count_o),
    .irq      (irq_o)
);

// File: tb/test_perf_sample_counter.sv
module test_perf_sample_counter;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [2:0]    cfg_addr;
    logic [DW-1:0] cfg_wdata;
    logic [DW-1:0] cfg_rdata;
    logic          ev_pulse;
    logic [LW-1:0] ev_lat;
    logic          priv;
    logic [DW-1:0] count;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        string         tag;
        bit            is_read;
        logic [DW-1:0] exp_val;
        logic          exp_irq;
    } item_t;

    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_sample_counter #(.DATA_W(DW), .LAT_W(LW)) i_perf_sample_counter (
        .clk_i       (clk),
        .rst_i       (rst),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .cfg_rdata_o (cfg_rdata),
        .ev_pulse_i  (ev_pulse),
        .ev_lat_i    (ev_lat),
        .priv_i      (priv),
        .count_o     (count),
        .irq_o       (irq)
    );

    // monitor: compares at the falling edge, before the driver changes inputs
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (it.is_read) begin
                    if (cfg_rdata !== it.exp_val) begin
                        errors++;
                        $display("FAIL %s rdata actual %0h expected %0h", it.tag, cfg_rdata, it.exp_val);
                    end
                end else if (count !== it.exp_val || irq !== it.exp_irq) begin
                    errors++;
                    $display("FAIL %s count/irq actual %0d/%0b expected %0d/%0b",
                             it.tag, count, irq, it.exp_val, it.exp_irq);
                end
            end
        end
    end

    task automatic step(input logic we, input logic [2:0] a, input logic [DW-1:0] d,
                        input logic p, input logic [LW-1:0] l, input logic pl);
        @(negedge clk);
        #1;
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        ev_pulse = p; ev_lat = l; priv = pl;
        @(posedge clk);
        #1;
        cfg_we = 1'b0; ev_pulse = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        step(1'b1, a, d, 1'b0, '0, 1'b0);
    endtask

    task automatic ev(input logic pl, input logic [LW-1:0] l);
        step(1'b0, 3'd0, '0, 1'b1, l, pl);
    endtask

    task automatic idle();
        step(1'b0, 3'd0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic expect_cnt(input string tag, input logic [DW-1:0] c, input logic i);
        item_t it;
        it.tag = tag; it.is_read = 1'b0; it.exp_val = c; it.exp_irq = i;
        sb.push_back(it);
    endtask

    task automatic expect_rd(input string tag, input logic [2:0] a, input logic [DW-1:0] v);
        item_t it;
        step(1'b0, a, '0, 1'b0, '0, 1'b0);
        it.tag = tag; it.is_read = 1'b1; it.exp_val = v; it.exp_irq = 1'b0;
        sb.push_back(it);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        ev_pulse = 1'b0; ev_lat = '0; priv = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        expect_cnt("R1 reset count/irq", 0, 1'b0);
        expect_rd("R1 reset control", 3'd0, 32'h0);

        // event mode, limit 5, both levels allowed
        wr(3'd1, 32'd5);
        wr(3'd0, 32'h0D);
        ev(1'b0, 12'd0); ev(1'b1, 12'd0); ev(1'b0, 12'd0);
        expect_cnt("R2 three events", 3, 1'b0);

        // privilege filter
        wr(3'd0, 32'h05);
        ev(1'b1, 12'd0);
        expect_cnt("R4 kernel refused", 3, 1'b0);
        wr(3'd0, 32'h09);
        ev(1'b0, 12'd0);
        expect_cnt("R4 user refused", 3, 1'b0);
        ev(1'b1, 12'd0);
        expect_cnt("R4 kernel counted", 4, 1'b0);
        wr(3'd0, 32'h05);
        ev(1'b0, 12'd0);
        expect_cnt("R3 fire at limit", 0, 1'b1);
        ev(1'b0, 12'd0);
        expect_cnt("R6 irq sticky while counting", 1, 1'b1);
        wr(3'd0, 32'h105);
        expect_cnt("R6 cleared by write", 1, 1'b0);

        // latency filter
        wr(3'd2, 32'd100);
        wr(3'd0, 32'h15);
        ev(1'b0, 12'd50);
        expect_cnt("R5 short latency ignored", 1, 1'b0);
        ev(1'b0, 12'd100);
        expect_cnt("R5 latency at minimum counts", 2, 1'b0);
        ev(1'b0, 12'd200);
        expect_cnt("R5 long latency counts", 3, 1'b0);

        // deferred limit change
        wr(3'd1, 32'd3);
        ev(1'b0, 12'd200);
        expect_cnt("R7 old limit still active", 4, 1'b0);
        ev(1'b0, 12'd200);
        expect_cnt("R7 fire at old limit", 0, 1'b1);
        wr(3'd0, 32'h115);
        ev(1'b0, 12'd200); ev(1'b0, 12'd200);
        expect_cnt("R7 below new limit", 2, 1'b0);
        ev(1'b0, 12'd200);
        expect_cnt("R7 fire at new limit", 0, 1'b1);

        // disabled
        wr(3'd0, 32'h100);
        expect_cnt("R6 clear while disabling", 0, 1'b0);
        ev(1'b0, 12'd200); ev(1'b1, 12'd200);
        expect_cnt("R8 disabled holds", 0, 1'b0);
        wr(3'd3, 32'd7);
        expect_cnt("R10 count write", 7, 1'b0);
        expect_rd("R10 count readback", 3'd3, 32'd7);
        expect_rd("R10 limit readback", 3'd1, 32'd3);
        expect_rd("R10 latency readback", 3'd2, 32'd100);

        // time mode, limit 4, no privilege allowed
        wr(3'd3, 32'd0);
        wr(3'd1, 32'd4);
        wr(3'd0, 32'h03);
        idle(); idle(); idle();
        expect_cnt("R9 time mode counts cycles", 3, 1'b0);
        idle();
        expect_cnt("R9 time mode fires", 0, 1'b1);
        expect_rd("R10 control readback with flag", 3'd0, 32'h103);
        expect_cnt("R9 keeps counting after fire", 1, 1'b1);

        // limit zero never fires
        wr(3'd0, 32'h100);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'h0D);
        ev(1'b0, 12'd0); ev(1'b0, 12'd0);
        expect_cnt("R7 zero limit never fires", 2, 1'b0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule